// File: doc/BRIEF.md
# DMA Interrupt Status Register Unit

This unit is the interrupt status and control register slice of a descriptor-driven DMA engine in an SD/MMC host controller. It latches single-cycle event pulses from the DMA core into sticky status bits. The events are transmit done, receive done, fatal bus error, descriptor unavailable and card error. Through an interrupt enable mask it forms a normal summary bit and an abnormal summary bit, and raises one interrupt line. Software clears each bit by writing a one to it over a simple word-addressed register bus.

A fatal bus error latches a 3-bit error code and drives a bus-disable output that stops all DMA bus traffic until software clears the error bit. The unit also holds the word-aligned base address of the descriptor list and presents it to the fetch engine.

Register word offsets on `bus_addr_i`: 0 is the descriptor base address, 1 is status, 2 is the interrupt enable. Status and enable share bit positions: transmit 0, receive 1, fatal 2, unavailable 4, card error 5. Status also holds normal summary 8, abnormal summary 9 and the error code in bits 12:10.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, all three registers read 0, and `irq_o` and `dma_bus_off_o` are low.
- R2: A pulse on `evt_tx_done_i`, `evt_rx_done_i` or `evt_desc_unavail_i` sets status bit 0, 1 or 4 at the next clock edge.
- R3: A pulse on any one of the seven `card_err_i` lines sets status bit 5.
- R4: A write to offset 1 clears each status bit whose data bit is 1. Data bits that are 0 leave status unchanged. If an event and a clear reach the same bit in one cycle, the bit stays set.
- R5: A fatal error sets bit 2, and `dma_bus_off_o` follows bit 2. The code is captured in bits 12:10 only when bit 2 was clear. Later errors do not change it. Clearing bit 2 returns the code to 0.
- R6: Bit 8 is set one cycle after status bit 0 or 1 is set and enabled. Bit 9 is set the same way from bits 2, 4 or 5. A cause that is not enabled sets neither bit.
- R7: Bits 8 and 9 are sticky. A write-one clear takes effect only if no enabled cause was set in the cycle of the write.
- R8: `irq_o` is high exactly when bit 8 or bit 9 is set.
- R9: The enable register at offset 2 stores only bits 0, 1, 2, 4 and 5. Its other bits read 0.
- R10: The base register at offset 0 stores bits 31:2. Bits 1:0 read 0, and `desc_base_o` carries the stored value.
- R11: Status bits 3, 6, 7 and 31:13 read 0. Bits 12:10 are not writable. Offsets other than 0, 1 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register word offset |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for `bus_addr_i` (combinational) |
| evt_tx_done_i | input | 1 | Descriptor transmit finished |
| evt_rx_done_i | input | 1 | Descriptor receive finished |
| evt_bus_err_i | input | 1 | Fatal bus error |
| evt_err_code_i | input | 3 | Type of the fatal bus error |
| evt_desc_unavail_i | input | 1 | Fetched descriptor not owned by DMA |
| card_err_i | input | CARD_ERR_N | Card error events |
| irq_o | output | 1 | Interrupt request |
| dma_bus_off_o | output | 1 | Blocks DMA bus accesses |
| desc_base_o | output | DW | Descriptor list base address |

## Verification
Two things can land on the same edge: an event setting a status bit and a software write-one clearing that same bit. The bench provokes this by driving an event pulse and a status write in one cycle, both for a status bit and for a summary bit whose cause is still present. It judges the result by reading the register back and checking that the bit survived. A second write, made after the cause is gone, must then clear it.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned N_EVT    = 5;
  localparam int unsigned EV_FBE   = 2;
  localparam int unsigned NIS_POS  = 8;
  localparam int unsigned AIS_POS  = 9;
  localparam int unsigned CODE_LSB = 10;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned OFS_BASE = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_MASK = 2;
  // event index -> tx, rx, fatal, unavail, card error
  localparam logic [N_EVT-1:0] NORM_GRP = 5'b00011;
  localparam logic [N_EVT-1:0] ABN_GRP  = 5'b11100;

  function automatic int unsigned evt_pos(int unsigned i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned N   = 5,
  parameter int unsigned FBE = 2,
  parameter int unsigned CW  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic [CW-1:0] code_i,
  output logic [N-1:0]  stat_o,
  output logic [CW-1:0] code_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= set_i[g] | (bit_q & ~clr_i[g]);  // set wins
    end
    assign stat_o[g] = bit_q;
  end

  logic [CW-1:0] code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          code_q <= '0;
    else if (set_i[FBE] && !stat_o[FBE])  code_q <= code_i;  // first error only
    else if (clr_i[FBE] && !set_i[FBE])   code_q <= '0;
  end
  assign code_o = code_q;
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary #(
  parameter int unsigned   N     = 5,
  parameter logic [N-1:0]  GROUP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_i,
  output logic         sum_o
);
  logic hit, sum_q;
  assign hit = |(stat_i & en_i & GROUP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= hit | (sum_q & ~clr_i);
  end
  assign sum_o = sum_q;
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif import dma_irq_pkg::*; #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] base_word_i,
  input  logic [DW-1:0] stat_word_i,
  input  logic [DW-1:0] mask_word_i,
  output logic          base_we_o,
  output logic          stat_we_o,
  output logic          mask_we_o,
  output logic [DW-1:0] rdata_o
);
  logic sel_base, sel_stat, sel_mask;
  assign sel_base = (bus_addr_i == AW'(OFS_BASE));
  assign sel_stat = (bus_addr_i == AW'(OFS_STAT));
  assign sel_mask = (bus_addr_i == AW'(OFS_MASK));

  assign base_we_o = bus_wr_i & sel_base;
  assign stat_we_o = bus_wr_i & sel_stat;
  assign mask_we_o = bus_wr_i & sel_mask;

  always_comb begin
    rdata_o = '0;
    if (sel_base) rdata_o = base_word_i;
    if (sel_stat) rdata_o = stat_word_i;
    if (sel_mask) rdata_o = mask_word_i;
  end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs import dma_irq_pkg::*; #(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 32,
  parameter int unsigned CARD_ERR_N = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_wr_i,
  input  logic [AW-1:0]         bus_addr_i,
  input  logic [DW-1:0]         bus_wdata_i,
  output logic [DW-1:0]         bus_rdata_o,
  input  logic                  evt_tx_done_i,
  input  logic                  evt_rx_done_i,
  input  logic                  evt_bus_err_i,
  input  logic [CODE_W-1:0]     evt_err_code_i,
  input  logic                  evt_desc_unavail_i,
  input  logic [CARD_ERR_N-1:0] card_err_i,
  output logic                  irq_o,
  output logic                  dma_bus_off_o,
  output logic [DW-1:0]         desc_base_o
);
  localparam int unsigned N = N_EVT;

  logic              base_we, stat_we, mask_we;
  logic [DW-1:2]     base_q;
  logic [N-1:0]      en_q, stat_q, set_v, clr_v;
  logic [CODE_W-1:0] code_q;
  logic              nis_q, ais_q;
  logic [DW-1:0]     base_word, stat_word, mask_word;

  assign set_v = {|card_err_i, evt_desc_unavail_i, evt_bus_err_i,
                  evt_rx_done_i, evt_tx_done_i};

  always_comb begin
    for (int i = 0; i < N; i++) clr_v[i] = stat_we & bus_wdata_i[evt_pos(i)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      en_q   <= '0;
    end else begin
      if (base_we) base_q <= bus_wdata_i[DW-1:2];
      if (mask_we)
        for (int i = 0; i < N; i++) en_q[i] <= bus_wdata_i[evt_pos(i)];
    end
  end

  dma_irq_status #(.N(N), .FBE(EV_FBE), .CW(CODE_W)) status_i (
    .clk_i, .rst_ni,
    .set_i  (set_v),
    .clr_i  (clr_v),
    .code_i (evt_err_code_i),
    .stat_o (stat_q),
    .code_o (code_q)
  );

  dma_irq_summary #(.N(N), .GROUP(NORM_GRP)) norm_i (
    .clk_i, .rst_ni,
    .stat_i (stat_q),
    .en_i   (en_q),
    .clr_i  (stat_we & bus_wdata_i[NIS_POS]),
    .sum_o  (nis_q)
  );

  dma_irq_summary #(.N(N), .GROUP(ABN_GRP)) abn_i (
    .clk_i, .rst_ni,
    .stat_i (stat_q),
    .en_i   (en_q),
    .clr_i  (stat_we & bus_wdata_i[AIS_POS]),
    .sum_o  (ais_q)
  );

  always_comb begin
    stat_word = '0;
    mask_word = '0;
    for (int i = 0; i < N; i++) begin
      stat_word[evt_pos(i)] = stat_q[i];
      mask_word[evt_pos(i)] = en_q[i];
    end
    stat_word[NIS_POS] = nis_q;
    stat_word[AIS_POS] = ais_q;
    stat_word[CODE_LSB +: CODE_W] = code_q;
  end
  assign base_word = {base_q, 2'b00};

  dma_irq_regif #(.AW(AW), .DW(DW)) regif_i (
    .bus_wr_i, .bus_addr_i,
    .base_word_i (base_word),
    .stat_word_i (stat_word),
    .mask_word_i (mask_word),
    .base_we_o   (base_we),
    .stat_we_o   (stat_we),
    .mask_we_o   (mask_we),
    .rdata_o     (bus_rdata_o)
  );

  assign irq_o         = nis_q | ais_q;
  assign dma_bus_off_o = stat_q[EV_FBE];
  assign desc_base_o   = base_word;
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk import dma_irq_pkg::*; #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic              evt_tx_done_i,
  input logic [N_EVT-1:0]  stat_q,
  input logic [N_EVT-1:0]  en_q,
  input logic [CODE_W-1:0] code_q,
  input logic              nis_q,
  input logic              ais_q
);
  logic stat_wr;
  assign stat_wr = bus_wr_i && (bus_addr_i == AW'(OFS_STAT));

  // R2
  tx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_tx_done_i |=> stat_q[0]);

  // R4
  tx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && bus_wdata_i[0] && !evt_tx_done_i) |=> !stat_q[0]);

  // R5
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[EV_FBE] && $past(stat_q[EV_FBE])) |-> $stable(code_q));

  // R6
  nis_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nis_q) |-> $past(|(stat_q & en_q & NORM_GRP)));

  // R7
  nis_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nis_q && !(stat_wr && bus_wdata_i[NIS_POS])) |=> nis_q);

  // R7
  ais_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_q && !(stat_wr && bus_wdata_i[AIS_POS])) |=> ais_q);
endmodule

bind dma_irq_regs dma_irq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .evt_tx_done_i (evt_tx_done_i),
  .stat_q        (stat_q),
  .en_q          (en_q),
  .code_q        (code_q),
  .nis_q         (nis_q),
  .ais_q         (ais_q)
);

// File: tb/dma_irq_regs_tb.sv
module dma_irq_regs_tb_top;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        bus_wr_i = 0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        evt_tx_done_i = 0, evt_rx_done_i = 0, evt_bus_err_i = 0;
  logic [2:0]  evt_err_code_i = '0;
  logic        evt_desc_unavail_i = 0;
  logic [6:0]  card_err_i = '0;
  logic        irq_o, dma_bus_off_o;
  logic [31:0] desc_base_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dma_irq_regs dut_i (.*);

  typedef struct packed {
    logic tx, rx, be; logic [2:0] code; logic du; logic [6:0] ce;
    logic wr; logic [3:0] addr; logic [31:0] wd;
    logic [31:0] exp; logic irq, off;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{0,0,0,3'd0,0,7'h00,1,4'd2,32'h037,32'h000,0,0}, // R9 enable all
    '{1,0,0,3'd0,0,7'h00,0,4'd0,32'h000,32'h101,1,0}, // R2 R6 tx
    '{0,1,0,3'd0,0,7'h00,0,4'd0,32'h000,32'h103,1,0}, // R2 rx
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h003,32'h100,1,0}, // R4 R7 clear causes
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h100,32'h000,0,0}, // R7 R8 clear summary
    '{0,0,0,3'd0,1,7'h00,0,4'd0,32'h000,32'h210,1,0}, // R2 R6 unavail
    '{0,0,0,3'd0,0,7'h04,0,4'd0,32'h000,32'h230,1,0}, // R3 card err
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h230,32'h200,1,0}, // R7 summary survives
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h200,32'h000,0,0}, // R7
    '{0,0,1,3'd5,0,7'h00,0,4'd0,32'h000,32'h1604,1,1},// R5 first error
    '{0,0,1,3'd2,0,7'h00,0,4'd0,32'h000,32'h1604,1,1},// R5 code held
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h204,32'h200,1,0}, // R5 release
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h200,32'h000,0,0}, // R8
    '{0,0,0,3'd0,0,7'h00,1,4'd2,32'h001,32'h000,0,0}, // R9 tx only
    '{0,1,0,3'd0,0,7'h00,0,4'd0,32'h000,32'h002,0,0}, // R6 masked rx
    '{0,0,0,3'd0,0,7'h00,1,4'd1,32'h002,32'h000,0,0}, // R4
    '{1,0,0,3'd0,0,7'h00,1,4'd1,32'h001,32'h101,1,0}  // R4 set beats clear
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 0; bus_wdata_i = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic clear_all();
    wr(4'd1, '1);
    wr(4'd1, '1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd(4'd0, r); chk("R1 base", r, 0);
    rd(4'd1, r); chk("R1 status", r, 0);
    rd(4'd2, r); chk("R1 mask", r, 0);
    chk("R1 irq/off", {30'd0, irq_o, dma_bus_off_o}, 0);
    rst_ni = 1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      evt_tx_done_i = VECS[v].tx; evt_rx_done_i = VECS[v].rx;
      evt_bus_err_i = VECS[v].be; evt_err_code_i = VECS[v].code;
      evt_desc_unavail_i = VECS[v].du; card_err_i = VECS[v].ce;
      bus_wr_i = VECS[v].wr; bus_addr_i = VECS[v].addr; bus_wdata_i = VECS[v].wd;
      @(negedge clk_i);
      evt_tx_done_i = 0; evt_rx_done_i = 0; evt_bus_err_i = 0; evt_err_code_i = 0;
      evt_desc_unavail_i = 0; card_err_i = 0;
      bus_wr_i = 0; bus_addr_i = 4'd1; bus_wdata_i = 0;
      @(negedge clk_i);
      #1;
      chk($sformatf("R4 R5 R6 status vec %0d", v), bus_rdata_o, VECS[v].exp);
      chk($sformatf("R8 irq vec %0d", v), {31'd0, irq_o}, {31'd0, VECS[v].irq});
      chk($sformatf("R5 bus off vec %0d", v), {31'd0, dma_bus_off_o}, {31'd0, VECS[v].off});
    end

    clear_all();
    // R10 base address alignment
    wr(4'd0, 32'hDEADBEEF);
    rd(4'd0, r); chk("R10 base read", r, 32'hDEADBEEC);
    chk("R10 base out", desc_base_o, 32'hDEADBEEC);
    // R9 mask storage
    wr(4'd2, '1);
    rd(4'd2, r); chk("R9 mask read", r, 32'h37);
    // R11 unmapped offset
    rd(4'd3, r); chk("R11 unmapped", r, 0);

    // R11 all events at once: reserved bits stay 0
    @(negedge clk_i);
    evt_tx_done_i = 1; evt_rx_done_i = 1; evt_bus_err_i = 1; evt_err_code_i = 3'd7;
    evt_desc_unavail_i = 1; card_err_i = 7'h40;
    @(negedge clk_i);
    evt_tx_done_i = 0; evt_rx_done_i = 0; evt_bus_err_i = 0; evt_err_code_i = 0;
    evt_desc_unavail_i = 0; card_err_i = 0;
    rd(4'd1, r); chk("R11 full status", r, 32'h1F37);
    // R4 write of zero leaves status
    wr(4'd1, 32'h0);
    rd(4'd1, r); chk("R4 zero write", r, 32'h1F37);
    // R11 code field not writable
    wr(4'd1, 32'h1C00);
    rd(4'd1, r); chk("R11 code ro", r, 32'h1F37);
    clear_all();
    rd(4'd1, r); chk("R7 cleared", r, 0);
    chk("R8 irq low", {31'd0, irq_o}, 0);

    // R3 each card error line
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      card_err_i = 7'(1 << k);
      @(negedge clk_i);
      card_err_i = '0;
      rd(4'd1, r);
      chk($sformatf("R3 card line %0d", k), r & 32'h20, 32'h20);
      clear_all();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule